// File: doc/BRIEF.md
# ADC Conversion Sequencer with Abort

This block is the digital sequencer on the device side of a successive-approximation converter that has a parallel read port. It samples an active-low conversion-start input and a free-running conversion clock, both synchronous to a fast system clock. It drives a busy flag and a track/hold control, where 1 means track and 0 means hold. When a conversion completes, it captures a 12-bit value from a stand-in comparator source. A host reads that value by pulling chip-select and read low together, in either full-word or byte-wide form.

After power-up the sequencer is disarmed and holds. It accepts conversions only after the start input has produced a rising edge. Each conversion counts conversion-clock edges. The track/hold control returns to track on the 13th rising edge. The result is captured on the 14th falling edge. If the start input rises before that edge, the conversion is cancelled and the stored result is kept.

Top module: `adc_conv_seq`

## Requirements
- R1: During and after reset, busy=0, track=0 (hold), bus_oe=0 and bus_data=0.
- R2: Before arming, a falling edge on start_n is ignored and busy stays 0. A rising edge on start_n arms the block and sets track=1 on the next clock.
- R3: When armed and idle, a falling edge on start_n sets busy=1 and track=0 (hold) on the next clock.
- R4: While busy, track stays 0 until the 13th rising edge of conv_clk after the start edge, and becomes 1 on that edge.
- R5: On the 14th falling edge of conv_clk, busy goes to 0 and track to 1, and cmp_data is stored as the new result.
- R6: If start_n rises while busy, before the 14th falling edge, the conversion is aborted: busy goes to 0, track to 1, and the stored result is unchanged.
- R7: bus_oe is 1 exactly when cs_n=0 and rd_n=0. Otherwise bus_data is 0, which stands in for a released bus.
- R8: With word_mode=1, an enabled bus shows all 12 result bits.
- R9: With word_mode=0, reads alternate between the low 8 bits and the high 4 bits, each zero-extended to 12 bits. The pointer advances when a read ends (bus_oe going 0) and starts on the low byte.
- R10: A completed conversion resets the byte pointer to the low byte.
- R11: With cs_n and rd_n held at 0 in word mode, the bus shows the old result while busy=1 and the new result from the cycle in which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Conversion start, active low; rising edge arms or aborts |
| conv_clk | input | 1 | Free-running conversion clock, sampled by clk |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| word_mode | input | 1 | 1: full-width output, 0: byte-wide output |
| cmp_data | input | 12 | Stand-in comparator result |
| busy | output | 1 | High while a conversion runs |
| track | output | 1 | 1: track, 0: hold |
| bus_oe | output | 1 | Bus output enable |
| bus_data | output | 12 | Parallel data, 0 when not enabled |

## Verification
Full conversions run all fourteen clock periods with random comparator values. They show that the 13th rise, rather than any earlier rise, restores track, and that capture happens on the 14th fall. Aborts are placed at random points from right after the start edge up to just after the 14th rise. These separate a correct abort, which keeps the old result and resumes track, from an early or late completion. Reads in byte and word mode are mixed at random between conversions. A read that is held for a whole conversion shows whether the bus switches to the new value in the same cycle that busy falls.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
    parameter int N = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] & prev_q[i];
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int TRACK_RISE = 13,
    parameter int END_FALL   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic start_fall,
    input  logic cclk_rise,
    input  logic cclk_fall,
    output logic busy,
    output logic track,
    output logic done
);
    localparam int CNT_MAX = (TRACK_RISE > END_FALL) ? TRACK_RISE : END_FALL;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(TRACK_RISE - 1);
    localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(END_FALL - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             armed;
        logic             track;
        logic             busy;
        logic [CNT_W-1:0] rises;
        logic [CNT_W-1:0] falls;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        done = 1'b0;
        case (c_q.st)
            SEQ_IDLE: begin
                if (!c_q.armed) begin
                    if (start_rise) begin
                        c_d.armed = 1'b1;
                        c_d.track = 1'b1;
                    end
                end else if (start_fall) begin
                    c_d.st    = SEQ_CONV;
                    c_d.busy  = 1'b1;
                    c_d.track = 1'b0;
                    c_d.rises = '0;
                    c_d.falls = '0;
                end
            end
            SEQ_CONV: begin
                if (start_rise) begin
                    c_d.st    = SEQ_IDLE;
                    c_d.busy  = 1'b0;
                    c_d.track = 1'b1;
                end else begin
                    if (cclk_rise && (c_q.rises <= RISE_LAST)) begin
                        c_d.rises = c_q.rises + 1'b1;
                        if (c_q.rises == RISE_LAST) c_d.track = 1'b1;
                    end
                    if (cclk_fall) begin
                        c_d.falls = c_q.falls + 1'b1;
                        if (c_q.falls == FALL_LAST) begin
                            done      = 1'b1;
                            c_d.st    = SEQ_IDLE;
                            c_d.busy  = 1'b0;
                            c_d.track = 1'b1;
                        end
                    end
                end
            end
            default: c_d = c_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: SEQ_IDLE, armed: 1'b0, track: 1'b0, busy: 1'b0,
                     rises: '0, falls: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy  = c_q.busy;
    assign track = c_q.track;

    a_r3_hold_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.busy) |-> !c_q.track);
    a_r6_track_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(c_q.busy) |-> c_q.track);
    a_r2_arm_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.armed) |-> c_q.track);
    a_r5_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !c_q.busy);
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              rd_en,
    input  logic              word_mode,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);
    localparam int HI_W = DATA_W - BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              hi_ptr;
        logic              rd_prev;
    } res_t;

    res_t r_d, r_q;
    logic rd_end;

    always_comb begin
        r_d         = r_q;
        rd_end      = r_q.rd_prev & ~rd_en;
        r_d.rd_prev = rd_en;
        if (done) begin
            r_d.result = cmp_data;
            r_d.hi_ptr = 1'b0;
        end else if (rd_end && !word_mode) begin
            r_d.hi_ptr = ~r_q.hi_ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_oe = rd_en;
        if (!rd_en)
            bus_data = '0;
        else if (word_mode)
            bus_data = r_q.result;
        else if (r_q.hi_ptr)
            bus_data = DATA_W'(r_q.result[DATA_W-1 -: HI_W]);
        else
            bus_data = DATA_W'(r_q.result[BYTE_W-1:0]);
    end

    a_r6_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(r_q.result));
    a_r10_ptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !r_q.hi_ptr);
    a_r7_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_data == '0));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int DATA_W     = 12,
    parameter int BYTE_W     = 8,
    parameter int TRACK_RISE = 13,
    parameter int END_FALL   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              conv_clk,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              busy,
    output logic              track,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_data
);
    logic [1:0] rise, fall;
    logic       done;
    logic       rd_en;

    assign rd_en = ~cs_n & ~rd_n;

    adc_seq_edge #(.N(2), .RST_VAL(2'b01)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({conv_clk, start_n}),
        .rise  (rise),
        .fall  (fall)
    );

    adc_seq_ctrl #(.TRACK_RISE(TRACK_RISE), .END_FALL(END_FALL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (rise[0]),
        .start_fall (fall[0]),
        .cclk_rise  (rise[1]),
        .cclk_fall  (fall[1]),
        .busy       (busy),
        .track      (track),
        .done       (done)
    );

    adc_seq_result #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .cmp_data  (cmp_data),
        .rd_en     (rd_en),
        .word_mode (word_mode),
        .bus_oe    (bus_oe),
        .bus_data  (bus_data)
    );
endmodule

// File: tb/tb_adc_conv_seq.sv
`timescale 1ns/1ps
module tb_adc_conv_seq;
    logic        clk = 1'b0;
    logic        rst_n, start_n, conv_clk, cs_n, rd_n, word_mode;
    logic [11:0] cmp_data;
    logic        busy, track, bus_oe;
    logic [11:0] bus_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [11:0] exp_result = '0;
    bit exp_ptr = 0;

    always #2.5 clk = ~clk;

    adc_conv_seq dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .conv_clk(conv_clk),
        .cs_n(cs_n), .rd_n(rd_n), .word_mode(word_mode), .cmp_data(cmp_data),
        .busy(busy), .track(track), .bus_oe(bus_oe), .bus_data(bus_data)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] exp_bus(input logic [11:0] res, input bit wm, input bit hi);
        if (wm) return res;
        if (hi) return {8'h00, res[11:8]};
        return {4'h0, res[7:0]};
    endfunction

    task automatic held_chk();
        if (!cs_n && !rd_n && word_mode) chk("R11 held bus", bus_data, exp_result);
    endtask

    task automatic do_read(input bit wm);
        word_mode = wm; cs_n = 0; rd_n = 0;
        tick();
        chk("R7 oe on", bus_oe, 1);
        chk(wm ? "R8 word data" : "R9 byte data", bus_data, exp_bus(exp_result, wm, exp_ptr));
        cs_n = 1; rd_n = 1;
        tick();
        chk("R7 oe off", bus_oe, 0);
        chk("R7 data quiet", bus_data, 0);
        if (!wm) exp_ptr = ~exp_ptr;
    endtask

    task automatic run_conv(input int pairs, input bit extra, input bit abrt, input logic [11:0] val);
        int r;
        r = 0;
        cmp_data = val;
        start_n = 0;
        tick();
        chk("R3 busy set", busy, 1);
        chk("R3 hold", track, 0);
        held_chk();
        for (int i = 1; i <= 14; i++) begin
            if (abrt && i == pairs + 1 && !extra) break;
            conv_clk = 1;
            tick();
            r++;
            chk("R4 track vs rises", track, (r >= 13) ? 1 : 0);
            chk("R4 busy during", busy, 1);
            held_chk();
            if (abrt && i == pairs + 1) break;
            conv_clk = 0;
            tick();
            if (i == 14) begin
                exp_result = val;
                exp_ptr = 0;
                chk("R5 busy end", busy, 0);
                chk("R5 track end", track, 1);
            end else begin
                chk("R5 busy kept", busy, 1);
            end
            held_chk();
        end
        start_n = 1;
        tick();
        if (abrt) begin
            chk("R6 abort busy", busy, 0);
            chk("R6 abort track", track, 1);
            held_chk();
        end
        conv_clk = 0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; start_n = 1; conv_clk = 0; cs_n = 1; rd_n = 1;
        word_mode = 1; cmp_data = '0;
        repeat (3) tick();
        chk("R1 busy", busy, 0);
        chk("R1 track", track, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 data", bus_data, 0);
        rst_n = 1;
        tick();
        // R2: falling start before arming is ignored
        start_n = 0;
        tick();
        tick();
        chk("R2 no busy unarmed", busy, 0);
        chk("R2 still hold", track, 0);
        start_n = 1;
        tick();
        chk("R2 armed track", track, 1);
        chk("R2 busy idle", busy, 0);

        // directed full conversion and reads
        run_conv(0, 0, 0, 12'hA5C);
        do_read(1);
        do_read(0);
        do_read(0);
        do_read(0);
        // R10: pointer left on high byte, a new conversion resets it
        run_conv(0, 0, 0, 12'h3E7);
        do_read(0);
        do_read(0);
        // R6: abort right after start, and just after the 14th rise
        run_conv(0, 0, 1, 12'hFFF);
        do_read(1);
        run_conv(13, 1, 1, 12'h111);
        do_read(1);
        // R11: read held low across a conversion
        word_mode = 1; cs_n = 0; rd_n = 0;
        tick();
        run_conv(0, 0, 0, 12'h9B2);
        chk("R11 new after", bus_data, 12'h9B2);
        cs_n = 1; rd_n = 1;
        tick();

        for (int it = 0; it < 40; it++) begin
            bit ab;
            ab = ($urandom_range(0, 2) == 0);
            run_conv($urandom_range(0, 13), 1'($urandom_range(0, 1)), ab,
                     12'($urandom_range(0, 4095)));
            for (int k = 0; k < $urandom_range(1, 3); k++)
                do_read(1'($urandom_range(0, 1)));
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule